// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder (16 bit)

This block adds two 16-bit unsigned operands and a carry-in and gives a 16-bit sum and a carry-out. It is purely combinational: no clock, no state, and outputs follow the inputs within the same evaluation. Operands in two's complement give the correct two's complement sum when the carry-out is ignored.

The datapath is cut into four 4-bit slices. Each slice forms per-bit generate (a AND b) and propagate (a XOR b). It then computes its internal carries as flat sum-of-products terms in those signals and its own carry-in, and reports one slice propagate and one slice generate. A second-level lookahead unit takes the four slice propagate/generate pairs and the external carry-in. It uses the same flat equations to produce the carry into every slice and the final carry-out. No carry passes serially from one slice to the next, so the depth of the carry path does not grow with the number of slices.

Top module: `cla_adder16`

## Requirements
- R1: For every input combination, {carry_out, sum_out} equals the 17-bit unsigned value a_in + b_in + carry_in.
- R2: A slice in which a_in XOR b_in is 1 on all four bits passes its incoming carry on unchanged: a_in=0x0FFF, b_in=0x0000, carry_in=1 gives sum_out=0x1000, carry_out=0.
- R3: A slice with a bit where a_in AND b_in is 1, and only propagating bits above it in the slice, sends a carry into the next slice whatever its own carry-in: 0x0080+0x0080 gives 0x0100 with carry_out=0, and 0xF800+0x0800 gives 0x0000 with carry_out=1.
- R4: A slice where a_in and b_in are both 0 on all four bits stops any incoming carry: a_in=0xF0FF, b_in=0x0000, carry_in=1 gives sum_out=0xF100, carry_out=0.
- R5: The all-ones-plus-one worst case carries through all four slices: 0xFFFF+0x0001 with carry_in=0, and 0xFFFF+0x0000 with carry_in=1, both give sum_out=0x0000, carry_out=1.
- R6: The largest input, 0xFFFF+0xFFFF with carry_in=1, gives sum_out=0xFFFF, carry_out=1.
- R7: The outputs depend only on the present inputs, and all-zero inputs give sum_out=0x0000 and carry_out=0, with no clock or reset needed.
- R8: The carry the second-level unit gives each slice equals the carry-out that the slice below computes from its own bits and carry-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
A wrong slice propagate or generate term does not show up in the slice's own sum bits. It shows only in the next slice up, and only when that slice's carry depends on it. Vectors must therefore push a carry across slice boundaries through propagate, generate and kill patterns. Because the block holds no state, any fault is visible in the same input vector that excites it, and never in a later one. Directed boundary vectors cover each slice pattern, and random vectors cover the mixed cases.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Default geometry: four slices of four bits
    parameter int unsigned CLA_GRP_W   = 4;
    parameter int unsigned CLA_NUM_GRP = 4;
    localparam int unsigned CLA_DATA_W = CLA_GRP_W * CLA_NUM_GRP;

    // Propagate / generate pair, used per bit and per slice
    typedef struct packed {
        logic prop;
        logic gen;
    } pg_t;

    function automatic pg_t bit_pg(input logic a, input logic b);
        pg_t r;
        r.gen  = a & b;
        r.prop = a ^ b;
        return r;
    endfunction

endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  pg_t [N-1:0] in_pg,
    input  logic        cin,
    output logic [N:0]  carry,
    output pg_t         blk_pg
);

    // Flat sum-of-products: carry[k] = OR_j (g[j] & p[j+1..k-1]) | (p[0..k-1] & cin)
    always_comb begin
        logic term;
        logic prod;
        carry[0] = cin;
        for (int k = 1; k <= int'(N); k++) begin
            term = 1'b0;
            for (int j = 0; j < k; j++) begin
                prod = in_pg[j].gen;
                for (int m = j + 1; m < k; m++) begin
                    prod = prod & in_pg[m].prop;
                end
                term = term | prod;
            end
            prod = cin;
            for (int m = 0; m < k; m++) begin
                prod = prod & in_pg[m].prop;
            end
            carry[k] = term | prod;
        end
    end

    // Block propagate and generate, without carry-in
    always_comb begin
        logic prod;
        blk_pg.prop = 1'b1;
        blk_pg.gen  = 1'b0;
        for (int j = 0; j < int'(N); j++) begin
            blk_pg.prop = blk_pg.prop & in_pg[j].prop;
            prod = in_pg[j].gen;
            for (int m = j + 1; m < int'(N); m++) begin
                prod = prod & in_pg[m].prop;
            end
            blk_pg.gen = blk_pg.gen | prod;
        end
    end

    // Flat carries must agree with the one-step recurrence
    always_comb begin
        if (!$isunknown({in_pg, cin, carry})) begin
            for (int k = 1; k <= int'(N); k++) begin
                AST_LA_RECUR: assert (carry[k] == (in_pg[k-1].gen | (in_pg[k-1].prop & carry[k-1]))); // R1
            end
        end
    end

    always_comb begin
        if (!$isunknown({blk_pg, cin, carry[N]})) begin
            if (blk_pg.gen) begin
                AST_BLK_GEN: assert (carry[N]); // R3
            end
            if (blk_pg.prop) begin
                AST_BLK_PROP: assert (carry[N] == cin); // R2
            end
            if (!blk_pg.prop && !blk_pg.gen) begin
                AST_BLK_KILL: assert (!carry[N]); // R4
            end
        end
    end

endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output pg_t          grp_pg,
    output logic         grp_cout
);

    pg_t  [W-1:0] pg_vec;
    logic [W:0]   c_vec;

    for (genvar i = 0; i < int'(W); i++) begin : g_bit
        assign pg_vec[i] = bit_pg(a[i], b[i]);
        assign sum[i]    = pg_vec[i].prop ^ c_vec[i];
    end

    cla_lookahead #(.N(W)) u_la (
        .in_pg  (pg_vec),
        .cin    (cin),
        .carry  (c_vec),
        .blk_pg (grp_pg)
    );

    assign grp_cout = c_vec[W];

    always_comb begin
        if (!$isunknown({a, b, cin, sum, grp_cout})) begin
            AST_GROUP_SUM: assert ({grp_cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin})); // R1
        end
    end

endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit
    import cla_pkg::*;
#(
    parameter int unsigned G = 4
) (
    input  pg_t [G-1:0] grp_pg,
    input  logic        cin,
    output logic [G:0]  grp_carry
);

    pg_t top_pg;

    cla_lookahead #(.N(G)) u_la2 (
        .in_pg  (grp_pg),
        .cin    (cin),
        .carry  (grp_carry),
        .blk_pg (top_pg)
    );

    always_comb begin
        if (!$isunknown({top_pg, cin, grp_carry[G]})) begin
            if (top_pg.prop) begin
                AST_ALL_PROP: assert (grp_carry[G] == cin); // R5
            end
            if (top_pg.gen) begin
                AST_ALL_GEN: assert (grp_carry[G]); // R3
            end
        end
    end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
    import cla_pkg::*;
#(
    parameter int unsigned GRP_W   = CLA_GRP_W,
    parameter int unsigned NUM_GRP = CLA_NUM_GRP
) (
    input  logic [GRP_W*NUM_GRP-1:0] a_in,
    input  logic [GRP_W*NUM_GRP-1:0] b_in,
    input  logic                     carry_in,
    output logic [GRP_W*NUM_GRP-1:0] sum_out,
    output logic                     carry_out
);

    localparam int unsigned DW = GRP_W * NUM_GRP;

    pg_t  [NUM_GRP-1:0] grp_pg;
    logic [NUM_GRP-1:0] grp_cout;
    logic [NUM_GRP:0]   grp_carry;

    for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_slice
        cla_group #(.W(GRP_W)) u_grp (
            .a        (a_in[g*GRP_W +: GRP_W]),
            .b        (b_in[g*GRP_W +: GRP_W]),
            .cin      (grp_carry[g]),
            .sum      (sum_out[g*GRP_W +: GRP_W]),
            .grp_pg   (grp_pg[g]),
            .grp_cout (grp_cout[g])
        );
    end

    cla_carry_unit #(.G(NUM_GRP)) u_cu (
        .grp_pg    (grp_pg),
        .cin       (carry_in),
        .grp_carry (grp_carry)
    );

    assign carry_out = grp_carry[NUM_GRP];

    // Second-level carries agree with each slice's own local carry-out
    always_comb begin
        if (!$isunknown({grp_cout, grp_carry})) begin
            for (int g = 0; g < int'(NUM_GRP); g++) begin
                AST_CARRY_AGREE: assert (grp_carry[g+1] == grp_cout[g]); // R8
            end
        end
    end

    always_comb begin
        if (!$isunknown({a_in, b_in, carry_in, sum_out, carry_out})) begin
            AST_TOTAL_SUM: assert ({carry_out, sum_out} == ({1'b0, a_in} + {1'b0, b_in} + {{DW{1'b0}}, carry_in})); // R1
        end
    end

endmodule

// File: tb/sim_cla_adder16.sv
`timescale 1ns/1ps
module sim_cla_adder16;

    localparam int unsigned DW = 16;
    localparam int unsigned N_RAND = 3000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] a_in = '0;
    logic [DW-1:0] b_in = '0;
    logic          carry_in = 1'b0;
    logic [DW-1:0] sum_out;
    logic          carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cla_adder16 u0 (
        .a_in      (a_in),
        .b_in      (b_in),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    function automatic logic [DW:0] model(input logic [DW-1:0] a, input logic [DW-1:0] b, input logic c);
        return {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, c};
    endfunction

    task automatic compare(input string tag, input logic [DW:0] expv);
        n_checks++;
        if ({carry_out, sum_out} !== expv) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h c=%b actual=%h expected=%h",
                     tag, a_in, b_in, carry_in, {carry_out, sum_out}, expv);
        end
    endtask

    // Drive away from the clock edge, sample 1 ns later
    task automatic apply(input string tag, input logic [DW-1:0] a, input logic [DW-1:0] b,
                         input logic c, input logic [DW:0] expv);
        @(negedge clk);
        a_in = a; b_in = b; carry_in = c;
        #1;
        compare(tag, expv);
        compare(tag, model(a, b, c));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        // R7: zero inputs give zero outputs while the bench is still in reset
        @(negedge clk); #1;
        compare("R7 zero", 17'h0_0000);
        @(posedge clk);
        rst = 1'b0;

        apply("R2 slice propagate", 16'h0FFF, 16'h0000, 1'b1, 17'h0_1000);
        apply("R2 propagate no cin", 16'h0F0F, 16'h00F0, 1'b0, 17'h0_0FFF);
        apply("R3 generate mid",    16'h0080, 16'h0080, 1'b0, 17'h0_0100);
        apply("R3 generate top",    16'hF800, 16'h0800, 1'b0, 17'h1_0000);
        apply("R4 slice kill",      16'hF0FF, 16'h0000, 1'b1, 17'h0_F100);
        apply("R5 ones plus one",   16'hFFFF, 16'h0001, 1'b0, 17'h1_0000);
        apply("R5 ones plus cin",   16'hFFFF, 16'h0000, 1'b1, 17'h1_0000);
        apply("R6 max",             16'hFFFF, 16'hFFFF, 1'b1, 17'h1_FFFF);
        apply("R8 slice boundary",  16'h000F, 16'h0001, 1'b0, 17'h0_0010);
        apply("R8 two boundaries",  16'h00FF, 16'h0001, 1'b0, 17'h0_0100);

        // R7: outputs follow a fresh vector within the same cycle
        @(negedge clk);
        a_in = 16'h1234; b_in = 16'h4321; carry_in = 1'b1;
        #0.5;
        compare("R7 same cycle", 17'h0_5556);

        // R1: random vectors, some biased toward long propagate runs
        for (int i = 0; i < int'(N_RAND); i++) begin
            logic [DW-1:0] ra;
            logic [DW-1:0] rb;
            logic          rc;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rc = 1'($urandom);
            if (i % 4 == 1) rb = ~ra ^ 16'($urandom_range(0, 15));
            apply("R1 random", ra, rb, rc, model(ra, rb, rc));
        end

        finish_run();
    end

endmodule